// File: doc/BRIEF.md
# Packet Network Controller Register Front End

This block is the programmed-I/O register front end of a small packet network controller. A host on a 16-bit word-addressed peripheral bus fills a one-packet outbound buffer word by word. It starts a transmission by reading a trigger register, and it drains a one-packet inbound buffer by reading a data register repeatedly. The bus side sees a command/status word, a station-address/transmit-data port, a receive-data port, a received bit count, the transmit trigger and an interval timer load. Upstream logic has already decoded the base address (by default 0764140), so `bus_addr` carries the word index, which is the byte offset divided by two.

On the line side, outbound words leave one per accepted `line_tx_valid`/`line_tx_ready` handshake. Inbound words arrive one per `line_rx_valid` strobe. The first word of every packet is its destination address. Line coding, CRC checking and collision detection live outside the block: their results arrive as the `line_rx_crc_err` flag on the final word and the `line_tx_abort` strobe. In loopback mode the outbound words are fed straight into the receiver. A single interrupt request merges receive, transmit and timer events, and the interrupt vector (default 0270) is a fixed output.

Top module: `netctl_regs`

## Requirements
- R1: After reset, the status word (word 0) reads 0x0080: only transmitter done (bit 7) is set. `irq` and `line_tx_valid` are low. Writes to the status bits 15, 14, 12:9, 7 and 6 have no effect.
- R2: A read of word 1 returns `station`. A write of word 1 appends one word to the outbound buffer. Writes made while the buffer holds DEPTH words, or while a transmission is running, are dropped.
- R3: A read of word 5 returns `station` and, when the outbound buffer is not empty and no transmission is running, sends the buffered words in write order. `line_tx_last` marks the final word, and the buffer is empty afterwards. Words 4, 6, 7 and 9..15 read as zero.
- R4: Transmitter done (bit 7) clears when a transmission starts and sets when its last word is accepted.
- R5: A `line_tx_abort` pulse during a transmission stops it and sets transmit aborted (bit 6) and transmitter done. The packet is kept, and the next start sends it again from its first word.
- R6: A packet is accepted when its first word equals `station`, equals zero, or accept-all (bit 2) is set. Any other packet is discarded.
- R7: At the end of an accepted packet, receive done (bit 15) sets and CRC error (bit 14) copies `line_rx_crc_err`. Word 3 then returns 16 times the stored word count in bits 11:0, with bits 15:12 zero.
- R8: Each read of word 2 returns the next stored received word in arrival order. Once receive done is set and every stored word has been read, reads return zero.
- R9: A packet that would be accepted but arrives while receive done is set is discarded. The lost count (bits 12:9) counts such packets and saturates at 15.
- R10: Writing 1 to receiver clear (bit 3) clears receive done, CRC error, the lost count and the receive buffer. Writing 1 to transmitter clear (bit 8) empties the outbound buffer, stops any transmission, clears transmit aborted and sets transmitter done. Both bits read as zero.
- R11: With loopback (bit 1) set, `line_tx_valid` stays low, the transmitted packet is delivered to the receiver with no CRC error, and the `line_rx_*` inputs are ignored.
- R12: A write of N > 0 to word 8 expires the timer exactly N clock edges later. A new load clears the expiry, and a load of zero leaves the timer idle.
- R13: Writing 1 to interface reset (bit 13) restores the reset state of R1, including the enables and the timer.
- R14: `irq` = (receive done AND receive enable bit 4) OR (transmitter done AND transmit enable bit 5) OR (timer expired AND timer enable bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| station | input | 16 | Station address from board switches (subnet 15:8, host 7:0) |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index within the register block |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current access |
| line_tx_valid | output | 1 | Outbound word valid |
| line_tx_data | output | 16 | Outbound word |
| line_tx_last | output | 1 | Outbound word is the last of the packet |
| line_tx_ready | input | 1 | Line accepts the outbound word |
| line_tx_abort | input | 1 | Transmission lost a conflict |
| line_rx_valid | input | 1 | Inbound word strobe |
| line_rx_data | input | 16 | Inbound word |
| line_rx_last | input | 1 | Inbound word ends the packet |
| line_rx_crc_err | input | 1 | CRC check failed, valid with the last word |
| irq | output | 1 | Interrupt request |
| int_vec | output | 9 | Interrupt vector |

## Verification
The assertions assume that the line stub raises `line_tx_abort` only as a single-cycle pulse and that it never presents an inbound word without a well-formed packet boundary. They also assume that bus accesses are single-cycle strobes, so one register read never triggers two pops or two starts. The stimulus keeps to this. Every bus access is one strobed cycle followed by an idle cycle. Inbound packets are always closed by a word that carries the last flag. Abort pulses last exactly one cycle and are issued only while a transmission waits on a stalled line. Ready and payload values are random, and the packet boundaries themselves are directed.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
  localparam int WORD_W = 16;
  localparam int LOST_W = 4;
  localparam int BITS_W = 12;

  // word indices of the register block
  localparam logic [3:0] RG_CSR  = 4'd0;
  localparam logic [3:0] RG_STN  = 4'd1;
  localparam logic [3:0] RG_RXD  = 4'd2;
  localparam logic [3:0] RG_BITS = 4'd3;
  localparam logic [3:0] RG_XMT  = 4'd5;
  localparam logic [3:0] RG_TMR  = 4'd8;

  // status word bit positions
  localparam int B_RDN  = 15;
  localparam int B_ERR  = 14;
  localparam int B_RST  = 13;
  localparam int B_LSTH = 12;
  localparam int B_LSTL = 9;
  localparam int B_TCL  = 8;
  localparam int B_TDN  = 7;
  localparam int B_TAB  = 6;
  localparam int B_TEN  = 5;
  localparam int B_REN  = 4;
  localparam int B_RCL  = 3;
  localparam int B_SPY  = 2;
  localparam int B_LPBK = 1;
  localparam int B_TIE  = 0;

  typedef struct packed {
    logic ten;
    logic ren;
    logic spy;
    logic lpbk;
    logic tie;
  } ctl_t;
endpackage

// File: rtl/netctl_txq.sv
module netctl_txq #(
  parameter int DEPTH = 16,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         start,
  input  logic         loop_en,
  input  logic         line_ready,
  input  logic         abort,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_last,
  output logic         done,
  output logic         aborted
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] wcnt_q, wcnt_d, rptr_q, rptr_d;
  logic          busy_q, busy_d, done_q, done_d, tab_q, tab_d;
  logic          xfer, abort_hit, at_last, can_push;

  assign xfer      = busy_q & (loop_en | line_ready);
  assign abort_hit = busy_q & abort & ~loop_en;
  assign at_last   = (rptr_q == wcnt_q - 1'b1);
  assign can_push  = push & ~busy_q & ~clr & (wcnt_q != FULL);

  always_comb begin
    wcnt_d = wcnt_q;
    rptr_d = rptr_q;
    busy_d = busy_q;
    done_d = done_q;
    tab_d  = tab_q;
    if (clr) begin
      wcnt_d = '0;
      rptr_d = '0;
      busy_d = 1'b0;
      done_d = 1'b1;
      tab_d  = 1'b0;
    end else if (abort_hit) begin
      busy_d = 1'b0;
      rptr_d = '0;
      done_d = 1'b1;
      tab_d  = 1'b1;
    end else if (busy_q) begin
      if (xfer) begin
        if (at_last) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          wcnt_d = '0;
          rptr_d = '0;
        end else begin
          rptr_d = rptr_q + 1'b1;
        end
      end
    end else if (start && wcnt_q != '0) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      tab_d  = 1'b0;
      rptr_d = '0;
    end else if (can_push) begin
      wcnt_d = wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      rptr_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b1;
      tab_q  <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      rptr_q <= rptr_d;
      busy_q <= busy_d;
      done_q <= done_d;
      tab_q  <= tab_d;
    end
  end

  always_ff @(posedge clk) begin
    if (can_push) mem[wcnt_q[IW-1:0]] <= push_data;
  end

  assign out_valid = busy_q;
  assign out_data  = mem[rptr_q[IW-1:0]];
  assign out_last  = busy_q & at_last;
  assign done      = done_q;
  assign aborted   = tab_q;

  p_busy_not_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !done_q);
  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= FULL);
  p_abort_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_hit && !clr) |=> (rptr_q == '0 && tab_q && !busy_q && wcnt_q != '0));
endmodule

// File: rtl/netctl_rxq.sv
module netctl_rxq
  import netctl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [W-1:0]      station,
  input  logic              spy,
  input  logic              in_valid,
  input  logic [W-1:0]      in_data,
  input  logic              in_last,
  input  logic              in_crc,
  input  logic              pop,
  output logic [W-1:0]      pop_data,
  output logic              rdn,
  output logic              err,
  output logic [LOST_W-1:0] lost,
  output logic [BITS_W-1:0] bits
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam int SH = $clog2(W);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]      mem [DEPTH];
  logic [CW-1:0]     wcnt_q, wcnt_d, rptr_q, rptr_d, base;
  logic              inpkt_q, inpkt_d, take_q, take_d;
  logic              rdn_q, rdn_d, err_q, err_d;
  logic [LOST_W-1:0] lost_q, lost_d;
  logic              first, match, take_now, store, can_pop;

  assign first    = ~inpkt_q;
  assign match    = spy | (in_data == station) | (in_data == '0);
  assign take_now = first ? (match & ~rdn_q) : take_q;
  assign base     = first ? '0 : wcnt_q;
  assign store    = in_valid & take_now & (base != FULL) & ~clr;
  assign can_pop  = rdn_q & (rptr_q < wcnt_q);

  always_comb begin
    wcnt_d  = wcnt_q;
    rptr_d  = rptr_q;
    inpkt_d = inpkt_q;
    take_d  = take_q;
    rdn_d   = rdn_q;
    err_d   = err_q;
    lost_d  = lost_q;
    if (clr) begin
      wcnt_d  = '0;
      rptr_d  = '0;
      inpkt_d = 1'b0;
      take_d  = 1'b0;
      rdn_d   = 1'b0;
      err_d   = 1'b0;
      lost_d  = '0;
    end else begin
      if (in_valid) begin
        if (first) begin
          take_d = take_now;
          if (match && rdn_q && lost_q != '1) lost_d = lost_q + 1'b1;
          if (take_now) begin
            wcnt_d = '0;
            rptr_d = '0;
          end
        end
        inpkt_d = ~in_last;
        if (store) wcnt_d = base + 1'b1;
        if (in_last && take_now) begin
          rdn_d = 1'b1;
          err_d = in_crc;
        end
      end
      if (pop && can_pop) rptr_d = rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      rptr_q  <= '0;
      inpkt_q <= 1'b0;
      take_q  <= 1'b0;
      rdn_q   <= 1'b0;
      err_q   <= 1'b0;
      lost_q  <= '0;
    end else begin
      wcnt_q  <= wcnt_d;
      rptr_q  <= rptr_d;
      inpkt_q <= inpkt_d;
      take_q  <= take_d;
      rdn_q   <= rdn_d;
      err_q   <= err_d;
      lost_q  <= lost_d;
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem[base[IW-1:0]] <= in_data;
  end

  assign pop_data = can_pop ? mem[rptr_q[IW-1:0]] : '0;
  assign rdn      = rdn_q;
  assign err      = err_q;
  assign lost     = lost_q;
  assign bits     = rdn_q ? (BITS_W'(wcnt_q) << SH) : '0;

  p_rdn_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdn_q && !clr) |=> rdn_q);
  p_lost_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q == '1 && !clr) |=> lost_q == '1);
  p_rptr_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_q <= wcnt_q);
endmodule

// File: rtl/netctl_tmr.sv
module netctl_tmr #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (clr) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (load) begin
      cnt_d = load_val;
      exp_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == TW'(1)) exp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired = exp_q;

  p_expire_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TW'(1) && !clr && !load) |=> expired);
  p_expire_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_q && !clr && !load) |=> expired);
endmodule

// File: rtl/netctl_regs.sv
module netctl_regs
  import netctl_pkg::*;
#(
  parameter int         DEPTH  = 16,
  parameter logic [8:0] VECTOR = 9'o270
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] station,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        line_tx_valid,
  output logic [15:0] line_tx_data,
  output logic        line_tx_last,
  input  logic        line_tx_ready,
  input  logic        line_tx_abort,
  input  logic        line_rx_valid,
  input  logic [15:0] line_rx_data,
  input  logic        line_rx_last,
  input  logic        line_rx_crc_err,
  output logic        irq,
  output logic [8:0]  int_vec
);
  ctl_t              ctl_q, ctl_d;
  logic              csr_wr, rst_req, tcl, rcl;
  logic              tx_push, tx_start, rx_pop, tmr_load;
  logic              tx_valid, tx_last, tx_done, tx_tab;
  logic [WORD_W-1:0] tx_data, rx_word;
  logic              rx_valid, rx_last, rx_crc;
  logic [WORD_W-1:0] pop_data;
  logic              rdn, err, tmr_exp;
  logic [LOST_W-1:0] lost;
  logic [BITS_W-1:0] bits;
  logic [15:0]       csr_view;

  assign csr_wr   = bus_sel & bus_wr & (bus_addr == RG_CSR);
  assign rst_req  = csr_wr & bus_wdata[B_RST];
  assign tcl      = rst_req | (csr_wr & bus_wdata[B_TCL]);
  assign rcl      = rst_req | (csr_wr & bus_wdata[B_RCL]);
  assign tx_push  = bus_sel & bus_wr & (bus_addr == RG_STN);
  assign tx_start = bus_sel & ~bus_wr & (bus_addr == RG_XMT);
  assign rx_pop   = bus_sel & ~bus_wr & (bus_addr == RG_RXD);
  assign tmr_load = bus_sel & bus_wr & (bus_addr == RG_TMR);

  always_comb begin
    ctl_d = ctl_q;
    if (rst_req) begin
      ctl_d = '0;
    end else if (csr_wr) begin
      ctl_d.ten  = bus_wdata[B_TEN];
      ctl_d.ren  = bus_wdata[B_REN];
      ctl_d.spy  = bus_wdata[B_SPY];
      ctl_d.lpbk = bus_wdata[B_LPBK];
      ctl_d.tie  = bus_wdata[B_TIE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  netctl_txq #(.DEPTH(DEPTH), .W(WORD_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tcl), .push(tx_push), .push_data(bus_wdata),
    .start(tx_start), .loop_en(ctl_q.lpbk), .line_ready(line_tx_ready),
    .abort(line_tx_abort), .out_valid(tx_valid), .out_data(tx_data),
    .out_last(tx_last), .done(tx_done), .aborted(tx_tab)
  );

  // loopback steers the outbound stream into the receiver
  assign rx_valid = ctl_q.lpbk ? tx_valid : line_rx_valid;
  assign rx_word  = ctl_q.lpbk ? tx_data  : line_rx_data;
  assign rx_last  = ctl_q.lpbk ? tx_last  : line_rx_last;
  assign rx_crc   = ctl_q.lpbk ? 1'b0     : line_rx_crc_err;

  netctl_rxq #(.DEPTH(DEPTH), .W(WORD_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rcl), .station(station), .spy(ctl_q.spy),
    .in_valid(rx_valid), .in_data(rx_word), .in_last(rx_last), .in_crc(rx_crc),
    .pop(rx_pop), .pop_data(pop_data), .rdn(rdn), .err(err), .lost(lost),
    .bits(bits)
  );

  netctl_tmr #(.TW(WORD_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(rst_req), .load(tmr_load),
    .load_val(bus_wdata), .expired(tmr_exp)
  );

  always_comb begin
    csr_view                = '0;
    csr_view[B_RDN]         = rdn;
    csr_view[B_ERR]         = err;
    csr_view[B_LSTH:B_LSTL] = lost;
    csr_view[B_TDN]         = tx_done;
    csr_view[B_TAB]         = tx_tab;
    csr_view[B_TEN]         = ctl_q.ten;
    csr_view[B_REN]         = ctl_q.ren;
    csr_view[B_SPY]         = ctl_q.spy;
    csr_view[B_LPBK]        = ctl_q.lpbk;
    csr_view[B_TIE]         = ctl_q.tie;
  end

  always_comb begin
    case (bus_addr)
      RG_CSR:         bus_rdata = csr_view;
      RG_STN, RG_XMT: bus_rdata = station;
      RG_RXD:         bus_rdata = pop_data;
      RG_BITS:        bus_rdata = {{(16-BITS_W){1'b0}}, bits};
      default:        bus_rdata = '0;
    endcase
  end

  assign line_tx_valid = tx_valid & ~ctl_q.lpbk;
  assign line_tx_data  = tx_data;
  assign line_tx_last  = tx_last & ~ctl_q.lpbk;
  assign irq     = (rdn & ctl_q.ren) | (tx_done & ctl_q.ten) | (tmr_exp & ctl_q.tie);
  assign int_vec = VECTOR;
endmodule

// File: tb/sim_netctl_regs.sv
module sim_netctl_regs;
  localparam int PER = 10;
  localparam int DEPTH = 16;
  localparam logic [15:0] STN = 16'h0A05;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        line_tx_valid, line_tx_last;
  logic [15:0] line_tx_data;
  logic        line_tx_ready = 1'b1, line_tx_abort = 1'b0;
  logic        line_rx_valid = 1'b0, line_rx_last = 1'b0, line_rx_crc_err = 1'b0;
  logic [15:0] line_rx_data = '0;
  logic        irq;
  logic [8:0]  int_vec;

  int checks = 0, failures = 0;
  int rdy_mode = 1;
  int cap_n = 0;
  logic [15:0] cap_w [64];
  logic        cap_l [64];
  logic [15:0] pkt [64];

  always #(PER/2) clk = ~clk;

  netctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .station(STN), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .line_tx_valid(line_tx_valid), .line_tx_data(line_tx_data),
    .line_tx_last(line_tx_last), .line_tx_ready(line_tx_ready),
    .line_tx_abort(line_tx_abort), .line_rx_valid(line_rx_valid),
    .line_rx_data(line_rx_data), .line_rx_last(line_rx_last),
    .line_rx_crc_err(line_rx_crc_err), .irq(irq), .int_vec(int_vec)
  );

  // line stub: pick ready, then record words that will transfer at the next edge
  always @(negedge clk) begin
    if (rdy_mode == 0)      line_tx_ready = ($urandom % 3) != 0;
    else if (rdy_mode == 1) line_tx_ready = 1'b1;
    else                    line_tx_ready = 1'b0;
    if (line_tx_valid && line_tx_ready && cap_n < 64) begin
      cap_w[cap_n] = line_tx_data;
      cap_l[cap_n] = line_tx_last;
      cap_n++;
    end
  end

  function automatic logic [15:0] csr_exp(logic rdn, logic err, logic [3:0] lost,
      logic tdn, logic tab, logic [4:0] en);
    return {rdn, err, 1'b0, lost, 1'b0, tdn, tab, en[4], en[3], 1'b0, en[2:0]};
  endfunction

  function automatic logic [15:0] bits_exp(int words);
    return 16'(words * 16);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
      input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #(PER/4);
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_tdn();
    logic [15:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(4'd0, v);
      if (v[7]) return;
    end
    check(1'b0, "TDN timeout R4", v, 16'h0080);
  endtask

  task automatic rx_send(input int n, input logic crc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_rx_valid = 1'b1; line_rx_data = pkt[i];
      line_rx_last = (i == n - 1); line_rx_crc_err = crc;
    end
    @(negedge clk);
    line_rx_valid = 1'b0; line_rx_last = 1'b0; line_rx_crc_err = 1'b0;
  endtask

  initial begin
    #(PER * 150000);
    failures++;
    $display("FAIL watchdog R1 actual=%h expected=%h", 16'h0, 16'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int len, n0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and read-only status bits
    rd(4'd0, v); check(v == 16'h0080, "R1 reset csr", v, 16'h0080);
    check(!irq && !line_tx_valid, "R1 irq/tx idle", {14'b0, irq, line_tx_valid}, 16'h0);
    wr(4'd0, 16'hDE40);
    rd(4'd0, v); check(v == 16'h0080, "R1 status not writable", v, 16'h0080);
    // R2 station read
    rd(4'd1, v); check(v == STN, "R2 station", v, STN);
    // R3 unused words
    rd(4'd4, v); check(v == 16'h0, "R3 unused 4", v, 16'h0);
    rd(4'd14, v); check(v == 16'h0, "R3 unused 14", v, 16'h0);

    // R3 R4 R14 random packets, random line readiness
    wr(4'd0, 16'h0020);
    rdy_mode = 0;
    for (int t = 0; t < 3; t++) begin
      len = 2 + int'($urandom % 6);
      for (int i = 0; i < len; i++) begin pkt[i] = 16'($urandom); wr(4'd1, pkt[i]); end
      cap_n = 0;
      rd(4'd5, v); check(v == STN, "R3 xmt returns station", v, STN);
      rd(4'd0, v); check(!v[7] || cap_n == len, "R4 tdn clear while sending", v, 16'h0);
      wait_tdn();
      check(cap_n == len, "R3 word count", 16'(cap_n), 16'(len));
      for (int i = 0; i < len && i < cap_n; i++) begin
        check(cap_w[i] == pkt[i], "R3 word order", cap_w[i], pkt[i]);
        check(cap_l[i] == (i == len - 1), "R3 last flag", 16'(cap_l[i]), 16'(i == len - 1));
      end
      #(PER/4);
      check(irq, "R14 irq on tdn&ten", 16'(irq), 16'h1);
    end
    rdy_mode = 1;
    cap_n = 0;
    rd(4'd5, v); repeat (4) @(negedge clk);
    check(cap_n == 0, "R3 empty after send", 16'(cap_n), 16'h0);

    // R2 overflow
    for (int i = 0; i < DEPTH + 3; i++) begin pkt[i] = 16'(i + 16'h100); wr(4'd1, pkt[i]); end
    cap_n = 0; rd(4'd5, v); wait_tdn();
    check(cap_n == DEPTH, "R2 full buffer drops", 16'(cap_n), 16'(DEPTH));
    check(cap_w[DEPTH-1] == pkt[DEPTH-1], "R2 last kept word", cap_w[DEPTH-1], pkt[DEPTH-1]);

    // R5 abort and retry
    wr(4'd0, 16'h0000);
    for (int i = 0; i < 4; i++) begin pkt[i] = 16'($urandom); wr(4'd1, pkt[i]); end
    rdy_mode = 2; cap_n = 0;
    rd(4'd5, v);
    @(negedge clk); line_tx_abort = 1'b1;
    @(negedge clk); line_tx_abort = 1'b0;
    rd(4'd0, v); check(v == 16'h00C0, "R5 tab+tdn", v, 16'h00C0);
    rdy_mode = 1;
    rd(4'd5, v); wait_tdn();
    check(cap_n == 4 && cap_w[0] == pkt[0] && cap_w[3] == pkt[3], "R5 resend",
          cap_w[0], pkt[0]);
    rd(4'd0, v); check(v == 16'h0080, "R5 tab cleared on start", v, 16'h0080);

    // R8 R10 transmitter clear
    wr(4'd1, 16'h1234);
    wr(4'd0, 16'h0100);
    cap_n = 0; rd(4'd5, v); repeat (4) @(negedge clk);
    check(cap_n == 0, "R10 tcl empties tx", 16'(cap_n), 16'h0);

    // R6 R7 R8 receive path
    wr(4'd0, 16'h0010);
    pkt[0] = STN;
    for (int i = 1; i < 4; i++) pkt[i] = 16'($urandom);
    rx_send(4, 1'b0);
    rd(4'd0, v); check(v == csr_exp(1, 0, 0, 1, 0, 5'b01000), "R7 rdn set", v,
                       csr_exp(1, 0, 0, 1, 0, 5'b01000));
    rd(4'd3, v); check(v == bits_exp(4), "R7 bit count", v, bits_exp(4));
    check(irq, "R14 irq on rdn&ren", 16'(irq), 16'h1);
    for (int i = 0; i < 4; i++) begin
      rd(4'd2, v); check(v == pkt[i], "R8 pop order", v, pkt[i]);
    end
    rd(4'd2, v); check(v == 16'h0, "R8 past end", v, 16'h0);

    wr(4'd0, 16'h0018);
    rd(4'd0, v); check(v == 16'h0090, "R10 rcl clears rdn", v, 16'h0090);
    pkt[0] = STN ^ 16'h0001; pkt[1] = 16'hBEEF;
    rx_send(2, 1'b0);
    rd(4'd0, v); check(!v[15], "R6 foreign packet dropped", v, 16'h0090);
    pkt[0] = 16'h0000; pkt[1] = 16'hCAFE;
    rx_send(2, 1'b0);
    rd(4'd0, v); check(v[15], "R6 broadcast accepted", v, 16'h8090);

    // R9 lost count saturation
    pkt[0] = STN; pkt[1] = 16'h5555;
    for (int k = 0; k < 17; k++) rx_send(2, 1'b0);
    rd(4'd0, v); check(v[12:9] == 4'hF, "R9 lost saturates", {12'b0, v[12:9]}, 16'hF);
    rd(4'd2, v); check(v == 16'h0000, "R9 lost packet not stored", v, 16'h0);
    wr(4'd0, 16'h0008);
    rd(4'd0, v); check(v == 16'h0080, "R10 rcl clears lost", v, 16'h0080);
    rd(4'd3, v); check(v == 16'h0, "R10 bit count cleared", v, 16'h0);

    // R6 R7 spy with crc error
    wr(4'd0, 16'h0004);
    pkt[0] = 16'h7777; pkt[1] = 16'h0101; pkt[2] = 16'h0202;
    rx_send(3, 1'b1);
    rd(4'd0, v); check(v == 16'hC084, "R6 R7 spy accepts, crc err", v, 16'hC084);
    rd(4'd3, v); check(v == bits_exp(3), "R7 bit count 3", v, bits_exp(3));

    // R11 loopback
    wr(4'd0, 16'h000A);
    pkt[0] = STN; pkt[1] = 16'($urandom); pkt[2] = 16'($urandom);
    for (int i = 0; i < 3; i++) wr(4'd1, pkt[i]);
    cap_n = 0; rd(4'd5, v); wait_tdn();
    check(cap_n == 0, "R11 no line output", 16'(cap_n), 16'h0);
    rd(4'd0, v); check(v == 16'h8082, "R11 looped packet received", v, 16'h8082);
    for (int i = 0; i < 3; i++) begin
      rd(4'd2, v); check(v == pkt[i], "R11 looped data", v, pkt[i]);
    end
    wr(4'd0, 16'h000A);
    pkt[0] = STN; pkt[1] = 16'h9999;
    rx_send(2, 1'b0);
    rd(4'd0, v); check(!v[15], "R11 line rx ignored", v, 16'h0082);

    // R12 timer
    wr(4'd0, 16'h0001);
    n0 = 5 + int'($urandom % 20);
    wr(4'd8, 16'(n0));
    repeat (n0 - 2) @(negedge clk);
    check(!irq, "R12 not yet expired", 16'(irq), 16'h0);
    repeat (2) @(negedge clk);
    check(irq, "R12 expired after N", 16'(irq), 16'h1);
    wr(4'd8, 16'h0000);
    repeat (5) @(negedge clk);
    check(!irq, "R12 zero load idle", 16'(irq), 16'h0);
    wr(4'd8, 16'd3);
    repeat (4) @(negedge clk);

    // R13 interface reset
    pkt[0] = STN; rx_send(1, 1'b0);
    wr(4'd1, 16'h4444);
    wr(4'd0, 16'h2000);
    rd(4'd0, v); check(v == 16'h0080, "R13 reset csr", v, 16'h0080);
    check(!irq, "R13 irq low", 16'(irq), 16'h0);
    cap_n = 0; rd(4'd5, v); repeat (4) @(negedge clk);
    check(cap_n == 0, "R13 tx buffer emptied", 16'(cap_n), 16'h0);
    check(int_vec == 9'o270, "R14 vector", {7'b0, int_vec}, 16'o270);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule